// File: doc/BRIEF.md
# Single-Wire Pulse-Count Configuration Decoder

This block listens to one control line driven by a host and turns short bursts of pulses on it into the configuration of an audio power amplifier. Each rising edge in a burst adds one to a counter. When the line then stays high for a validation interval, the counter value selects one setting and its value from a fixed table of 23 codes. The counter is then cleared for the next burst.

The same line also controls power. If the line stays low for a long interval, the amplifier is put into shutdown. While the block is in shutdown, the first rising edge starts a wake-up interval and reloads the default settings. The amplifier is enabled when that interval ends. The host therefore powers the amplifier up by raising the line, and it sends one burst for each setting it wants to change.

All intervals are counted in cycles of the system clock. They are derived from a clock-frequency parameter and from interval parameters given in microseconds. The pin is brought into the clock domain through a two-stage synchroniser.

Top module: `swcfg_decoder`

## Requirements
- R1: After reset the amplifier is disabled (`amp_en`=0) and the settings hold their defaults: `agc_en`=1, `gain_hi`=1, `thd_code`=0, `clip_only`=0, `plim_code`=7.
- R2: While in shutdown, a rising edge on `ctl_pin` reloads the defaults of R1. `amp_en` then rises once the line has been past the edge for WAKE_US microseconds. Edges that occur during this wake-up interval are not counted.
- R3: While enabled, if `ctl_pin` stays low for SHDN_US microseconds, `amp_en` falls to 0. Low gaps that are shorter than this leave `amp_en` at 1.
- R4: A burst takes effect only after the line has stayed high for VALID_US microseconds following its last rising edge. Before that, no setting output changes.
- R5: Count 1 sets `agc_en` to 0. Count 2 sets it to 1.
- R6: Count 3 restores every setting to the defaults of R1.
- R7: Count 4 sets `gain_hi` to 0 (12 dB). Count 5 sets it to 1 (18 dB).
- R8: Counts 6 to 13 set `thd_code` to count-6. Codes 0 to 7 stand for 1, 2, 4, 6, 8, 10, 15 and 20 percent.
- R9: Count 14 sets `clip_only` to 0, which means non-clip with power limit. Count 15 sets it to 1, which means non-clip only.
- R10: Counts 16 to 23 set `plim_code` to count-16. Codes 0 to 7 stand for 0.45 V to 3.6 V peak in steps of 0.45 V.
- R11: A burst of more than 23 edges changes no setting. The next burst is then counted from zero.
- R12: Each burst changes only the field that its count selects. All other fields keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_pin | input | 1 | Asynchronous single-wire control line |
| amp_en | output | 1 | 1 = amplifier active, 0 = shutdown or waking |
| agc_en | output | 1 | Automatic gain control enable |
| gain_hi | output | 1 | 1 = 18 dB, 0 = 12 dB |
| thd_code | output | 3 | Distortion limit code |
| clip_only | output | 1 | 1 = non-clip only, 0 = non-clip with power limit |
| plim_code | output | 3 | Power-limit level code |

## Verification
The assertions check on every cycle that the settings change only one cycle after the synchronised line was high, and that `amp_en` falls only after a low sample and rises only out of the wake-up state. They also check that an oversize count leaves the settings untouched, and that the AGC enable and the gain bit move only on their own codes or on a default reload. The mapping of every count to its field value, the separation of fields between bursts, the exact point at which a burst validates, and the shutdown and wake sequence are shown only by the bench's sweeps. These sweeps drive all 23 codes in ascending and descending order, send oversize bursts, and run full power cycles with an expected model kept alongside.

// File: rtl/swcfg_pkg.sv
package swcfg_pkg;

    localparam int CNT_W    = 5;
    localparam int CODE_MAX = 23;

    typedef struct packed {
        logic       agc;
        logic       gain_hi;
        logic [2:0] thd;
        logic       clip_only;
        logic [2:0] plim;
    } cfg_t;

    localparam cfg_t CFG_DEFAULT = '{agc: 1'b1, gain_hi: 1'b1, thd: 3'd0,
                                     clip_only: 1'b0, plim: 3'd7};

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAKE = 2'd1,
        ST_RUN  = 2'd2
    } pwr_state_e;

endpackage

// File: rtl/swcfg_sync.sv
module swcfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/swcfg_seq.sv
module swcfg_seq
    import swcfg_pkg::*;
#(
    parameter int VALID_CYC = 6720,
    parameter int SHDN_CYC  = 6720,
    parameter int WAKE_CYC  = 9600
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_i,
    output logic             amp_en_o,
    output logic             load_o,
    output logic             apply_o,
    output logic [CNT_W-1:0] apply_cnt_o
);
    localparam int HW = $clog2(VALID_CYC + 1);
    localparam int LW = $clog2(SHDN_CYC + 1);
    localparam int WW = $clog2(WAKE_CYC + 1);
    localparam logic [HW-1:0]    HI_LAST  = HW'(VALID_CYC - 1);
    localparam logic [HW-1:0]    HI_SAT   = HW'(VALID_CYC);
    localparam logic [LW-1:0]    LO_LAST  = LW'(SHDN_CYC - 1);
    localparam logic [LW-1:0]    LO_SAT   = LW'(SHDN_CYC);
    localparam logic [WW-1:0]    WK_LAST  = WW'(WAKE_CYC - 1);
    localparam logic [CNT_W-1:0] CNT_TOP  = '1;

    typedef struct packed {
        pwr_state_e       state;
        logic             line_prev;
        logic [CNT_W-1:0] cnt;
        logic [HW-1:0]    hi_run;
        logic [LW-1:0]    lo_run;
        logic [WW-1:0]    wk_run;
    } seq_t;

    seq_t q, d;
    logic rise;
    logic lo_expired;

    always_comb begin
        d           = q;
        load_o      = 1'b0;
        apply_o     = 1'b0;
        apply_cnt_o = q.cnt;
        rise        = line_i & ~q.line_prev;
        lo_expired  = ~line_i & (q.lo_run == LO_LAST);
        d.line_prev = line_i;

        if (line_i) d.hi_run = (q.hi_run == HI_SAT) ? q.hi_run : q.hi_run + 1'b1;
        else        d.hi_run = '0;
        if (!line_i) d.lo_run = (q.lo_run == LO_SAT) ? q.lo_run : q.lo_run + 1'b1;
        else         d.lo_run = '0;

        unique case (q.state)
            ST_OFF: begin
                if (rise) begin
                    d.state  = ST_WAKE;
                    d.wk_run = '0;
                    d.cnt    = '0;
                    load_o   = 1'b1;
                end
            end
            ST_WAKE: begin
                d.wk_run = q.wk_run + 1'b1;
                if (lo_expired)                d.state = ST_OFF;
                else if (q.wk_run == WK_LAST)  d.state = ST_RUN;
            end
            ST_RUN: begin
                if (rise && q.cnt != CNT_TOP) d.cnt = q.cnt + 1'b1;
                if (line_i && q.hi_run == HI_LAST && q.cnt != '0) begin
                    apply_o = 1'b1;
                    d.cnt   = '0;
                end
                if (lo_expired) begin
                    d.state = ST_OFF;
                    d.cnt   = '0;
                end
            end
            default: d.state = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_OFF, line_prev: 1'b0, cnt: '0,
                   hi_run: '0, lo_run: '0, wk_run: '0};
        end else begin
            q <= d;
        end
    end

    assign amp_en_o = (q.state == ST_RUN);

    // R3: shutdown is only ever entered after the line was sampled low
    p_shdn_after_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(amp_en_o) |-> $past(!line_i));

    // R2: the amplifier is only switched on out of the wake-up interval
    p_enable_from_wake_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(amp_en_o) |-> $past(q.state == ST_WAKE));
endmodule

// File: rtl/swcfg_table.sv
module swcfg_table
    import swcfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             apply_i,
    input  logic [CNT_W-1:0] cnt_i,
    output cfg_t             cfg_o
);
    cfg_t cfg_q, cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (load_i) begin
            cfg_d = CFG_DEFAULT;
        end else if (apply_i) begin
            unique case (cnt_i)
                5'd1:  cfg_d.agc       = 1'b0;
                5'd2:  cfg_d.agc       = 1'b1;
                5'd3:  cfg_d           = CFG_DEFAULT;
                5'd4:  cfg_d.gain_hi   = 1'b0;
                5'd5:  cfg_d.gain_hi   = 1'b1;
                5'd6, 5'd7, 5'd8, 5'd9, 5'd10, 5'd11, 5'd12, 5'd13:
                       cfg_d.thd       = cnt_i[2:0] - 3'd6;
                5'd14: cfg_d.clip_only = 1'b0;
                5'd15: cfg_d.clip_only = 1'b1;
                5'd16, 5'd17, 5'd18, 5'd19, 5'd20, 5'd21, 5'd22, 5'd23:
                       cfg_d.plim      = cnt_i[2:0];
                default: cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_DEFAULT;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

    // R11: an oversize count leaves every field untouched
    p_oversize_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (apply_i && !load_i && cnt_i > 5'(CODE_MAX)) |=> $stable(cfg_q));

    // R5: the AGC is only ever switched off by its own code
    p_agc_off_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_q.agc) |-> $past(apply_i && cnt_i == 5'd1));

    // R7: the gain only goes up through its code, the default code, or a reload
    p_gain_up_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_q.gain_hi) |-> $past(load_i || (apply_i && (cnt_i == 5'd5 || cnt_i == 5'd3))));
endmodule

// File: rtl/swcfg_decoder.sv
module swcfg_decoder
    import swcfg_pkg::*;
#(
    parameter int CLK_KHZ     = 19200,
    parameter int VALID_US    = 350,
    parameter int SHDN_US     = 350,
    parameter int WAKE_US     = 500,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_pin,
    output logic       amp_en,
    output logic       agc_en,
    output logic       gain_hi,
    output logic [2:0] thd_code,
    output logic       clip_only,
    output logic [2:0] plim_code
);
    localparam int VALID_CYC = (CLK_KHZ * VALID_US) / 1000;
    localparam int SHDN_CYC  = (CLK_KHZ * SHDN_US) / 1000;
    localparam int WAKE_CYC  = (CLK_KHZ * WAKE_US) / 1000;

    logic             line;
    logic             load;
    logic             apply;
    logic [CNT_W-1:0] apply_cnt;
    cfg_t             cfg;

    swcfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ctl_pin),
        .sync_o  (line)
    );

    swcfg_seq #(
        .VALID_CYC (VALID_CYC),
        .SHDN_CYC  (SHDN_CYC),
        .WAKE_CYC  (WAKE_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_i      (line),
        .amp_en_o    (amp_en),
        .load_o      (load),
        .apply_o     (apply),
        .apply_cnt_o (apply_cnt)
    );

    swcfg_table u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .apply_i (apply),
        .cnt_i   (apply_cnt),
        .cfg_o   (cfg)
    );

    assign agc_en    = cfg.agc;
    assign gain_hi   = cfg.gain_hi;
    assign thd_code  = cfg.thd;
    assign clip_only = cfg.clip_only;
    assign plim_code = cfg.plim;

    // R4: settings move only one cycle after the synchronised line was high
    p_change_needs_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg) |-> $past(line));
endmodule

// File: tb/swcfg_decoder_test.sv
module swcfg_decoder_test;
    localparam int VAL_C  = 60;
    localparam int SHD_C  = 60;
    localparam int WAK_C  = 80;
    localparam int HI_C   = 10;
    localparam int LO_C   = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_pin = 1'b0;
    logic       amp_en, agc_en, gain_hi, clip_only;
    logic [2:0] thd_code, plim_code;

    int n_cmp = 0;
    int n_bad = 0;

    logic       e_agc, e_gain, e_clip;
    logic [2:0] e_thd, e_plim;

    always #2.5 clk = ~clk;

    swcfg_decoder #(
        .CLK_KHZ (1000), .VALID_US (VAL_C), .SHDN_US (SHD_C), .WAKE_US (WAK_C)
    ) uut (
        .clk (clk), .rst_n (rst_n), .ctl_pin (ctl_pin),
        .amp_en (amp_en), .agc_en (agc_en), .gain_hi (gain_hi),
        .thd_code (thd_code), .clip_only (clip_only), .plim_code (plim_code)
    );

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_defaults();
        e_agc = 1'b1; e_gain = 1'b1; e_thd = 3'd0; e_clip = 1'b0; e_plim = 3'd7;
    endtask

    task automatic model(input int n);
        if (n == 1) e_agc = 1'b0;
        else if (n == 2) e_agc = 1'b1;
        else if (n == 3) set_defaults();
        else if (n == 4) e_gain = 1'b0;
        else if (n == 5) e_gain = 1'b1;
        else if (n >= 6 && n <= 13) e_thd = 3'(n - 6);
        else if (n == 14) e_clip = 1'b0;
        else if (n == 15) e_clip = 1'b1;
        else if (n >= 16 && n <= 23) e_plim = 3'(n - 16);
    endtask

    task automatic check_cfg(input string req);
        check(req, "agc_en",    int'(agc_en),    int'(e_agc));
        check(req, "gain_hi",   int'(gain_hi),   int'(e_gain));
        check(req, "thd_code",  int'(thd_code),  int'(e_thd));
        check(req, "clip_only", int'(clip_only), int'(e_clip));
        check(req, "plim_code", int'(plim_code), int'(e_plim));
    endtask

    // Line idles high; n rising edges, the last one followed by the validation high.
    task automatic burst(input int n, input bit check_early);
        for (int i = 0; i < n; i++) begin
            ctl_pin = 1'b0;
            wait_cyc(LO_C);
            ctl_pin = 1'b1;
            if (i < n - 1) wait_cyc(HI_C);
        end
        if (check_early) begin
            wait_cyc(VAL_C / 2);
            check_cfg("R4");
            wait_cyc(VAL_C / 2 + 20);
        end else begin
            wait_cyc(VAL_C + 20);
        end
    endtask

    task automatic power_up();
        ctl_pin = 1'b1;
        wait_cyc(WAK_C / 2);
        check("R2", "amp_en mid-wake", int'(amp_en), 0);
        wait_cyc(WAK_C / 2 + 20);
        check("R2", "amp_en after wake", int'(amp_en), 1);
        set_defaults();
        check_cfg("R2");
    endtask

    initial begin
        #(5ns * 150000);
        n_bad++;
        $display("FAIL R2 watchdog expired: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        set_defaults();
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(3);
        // R1: reset state
        check("R1", "amp_en", int'(amp_en), 0);
        check_cfg("R1");

        power_up();

        // R5..R10, R12: ascending sweep over every valid code, all fields compared
        for (int n = 1; n <= 23; n++) begin
            burst(n, (n % 4) == 0);
            model(n);
            check_cfg("R12");
        end
        // descending sweep from a non-default state
        for (int n = 23; n >= 1; n--) begin
            if (n == 3) continue;
            burst(n, 1'b0);
            model(n);
            check_cfg("R8");
        end
        // explicit field checks
        burst(13, 1'b0); model(13); check("R8", "thd 20%", int'(thd_code), 7);
        burst(17, 1'b0); model(17); check("R10", "plim 0.9V", int'(plim_code), 1);
        burst(15, 1'b0); model(15); check("R9", "non-clip only", int'(clip_only), 1);
        burst(4, 1'b0);  model(4);  check("R7", "gain 12dB", int'(gain_hi), 0);
        burst(1, 1'b0);  model(1);  check("R5", "agc off", int'(agc_en), 0);

        // R11: oversize bursts ignored, next burst counted from zero
        burst(24, 1'b1); check_cfg("R11");
        burst(31, 1'b0); check_cfg("R11");
        burst(2, 1'b0);  model(2); check_cfg("R11");
        check("R5", "agc on", int'(agc_en), 1);

        // R6: default code restores everything
        burst(3, 1'b0); model(3); check_cfg("R6");
        burst(20, 1'b0); model(20);

        // R3: short low keeps running, long low shuts down
        ctl_pin = 1'b0;
        wait_cyc(SHD_C / 2);
        check("R3", "amp_en short low", int'(amp_en), 1);
        wait_cyc(SHD_C / 2 + 20);
        check("R3", "amp_en long low", int'(amp_en), 0);
        check_cfg("R3");

        // R2: wake reloads defaults; edges during wake not counted
        ctl_pin = 1'b1;
        wait_cyc(20);
        for (int i = 0; i < 3; i++) begin
            ctl_pin = 1'b0; wait_cyc(LO_C); ctl_pin = 1'b1; wait_cyc(HI_C);
        end
        wait_cyc(WAK_C + VAL_C);
        check("R2", "amp_en woke", int'(amp_en), 1);
        set_defaults();
        check_cfg("R2");

        // second power cycle with a full reload check
        burst(9, 1'b0); model(9);
        ctl_pin = 1'b0;
        wait_cyc(SHD_C + 20);
        check("R3", "amp_en second shutdown", int'(amp_en), 0);
        power_up();
        burst(22, 1'b0); model(22); check_cfg("R10");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule